// File: doc/BRIEF.md
# Shadow-backed SRAM store controller

This block models a 16-bit wide static RAM with a second, shadow array behind it that keeps its contents across reset. The host reads and writes the working array through active-low strobes: chip enable, output enable, write enable and one enable per byte lane. The whole working array is copied into the shadow array in one step by a STORE. It is copied back in one step by a RECALL. Every transfer is synchronous, and its duration is a parameter counted in clock cycles.

Three sources can start a STORE:
- A shared open-drain handshake line, pulled low from outside.
- A rising edge on a power-fail input.
- A one-cycle software pulse.

The first two sources run a STORE only when the working array has been modified since the last transfer. Otherwise they are reported as skipped. While a STORE runs, the block pulls the handshake line low itself, so the same line carries both the request and the busy indication. After an external request there is a grace delay. During that delay, accesses that were already running may finish, but fresh writes are refused. A RECALL runs on its own after every reset.

Top module: `shadow_sram_ctrl`

## Requirements
- R1: A read is accepted when `ce_ni` and `oe_ni` are low and `we_ni` and `hs_ni` are high in the idle state. `rdata_o` and `rvalid_o` are presented one clock after the accepting edge. If any of these conditions is missing, `rvalid_o` stays low.
- R2: A write is accepted when `ce_ni` and `we_ni` are low and `hs_ni` is high in the idle state. `lane_lo_ni` low writes bits 7:0 and `lane_hi_ni` low writes bits 15:8. A lane whose enable is high keeps its old contents.
- R3: While `busy_o` is high, no read produces `rvalid_o` and no write changes the array.
- R4: An external request is `hs_ni` seen low in the idle state. With the modified latch set, `busy_o` rises on the DELAY_CYC+1-th rising edge after the request and stays high for STORE_CYC cycles.
- R5: A write already accepted in the cycle before `hs_ni` falls may continue and is accepted. A fresh write issued once `hs_ni` is low is refused.
- R6: An external request with the modified latch clear pulses `skipped_o` and leaves `hs_pull_o` low. All reads and writes are refused until `hs_ni` returns high.
- R7: `hs_pull_o` is high exactly while a STORE runs, whatever its cause. It is low during reset and during a RECALL.
- R8: A rising edge on `pwr_fail_i` in the idle state starts a STORE (`busy_o` high after one edge) when the modified latch is set. Otherwise it pulses `skipped_o`.
- R9: A `sw_store_i` pulse in the idle state always starts a STORE of STORE_CYC cycles, even with the modified latch clear.
- R10: A `recall_i` pulse in the idle state holds `busy_o` for RECALL_CYC cycles. It copies the shadow array back into the working array and clears the modified latch.
- R11: `busy_o` is high during reset and for RECALL_CYC cycles after its release. Data stored before reset reads back afterwards.
- R12: The modified latch is set only by an accepted write with at least one lane enabled. It is cleared when a STORE or a RECALL completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| lane_lo_ni | input | 1 | Low byte lane enable, active low |
| lane_hi_ni | input | 1 | High byte lane enable, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle after acceptance |
| hs_ni | input | 1 | Resolved level of the open-drain handshake line |
| hs_pull_o | output | 1 | Pulls the handshake line low while storing |
| sw_store_i | input | 1 | Unconditional store pulse |
| recall_i | input | 1 | Recall pulse |
| pwr_fail_i | input | 1 | Power-fail level; its rising edge requests a store |
| busy_o | output | 1 | STORE or RECALL in progress |
| skipped_o | output | 1 | One-cycle pulse when a conditional store is skipped |

## Verification
The assertions assume three things about the inputs:
- Every strobe is synchronous to the clock and holds its level for whole cycles.
- The handshake line is the wired-AND of the block's own pull and an external pull.
- Requests arrive only while the block is idle, and the `sw_store_i` and `recall_i` pulses last a single cycle.

The stimulus follows these assumptions as follows. It changes every input half a cycle away from the sampling edge. It builds the line level from `hs_pull_o` and its own external pull. It waits for `busy_o` to fall and for the line to be released before it issues the next request.

// File: rtl/shsr_pkg.sv
package shsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_STORE,
    ST_RECALL,
    ST_HOLD
  } shsr_state_e;
endpackage

// File: rtl/shsr_gate.sv
module shsr_gate
  import shsr_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  lane_ni,
  input  logic              pin_i,
  input  shsr_state_e       state_i,
  input  logic              latch_i,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic              wr_fire_o
);
  logic prev_rd_q, prev_wr_q;
  logic open_bus, grace;

  assign open_bus = (state_i == ST_IDLE) && pin_i;
  // grace: request seen with dirty array, or delay window running
  assign grace = (state_i == ST_DELAY) ||
                 ((state_i == ST_IDLE) && !pin_i && latch_i);

  assign rd_ok_o = !ce_ni && !oe_ni && we_ni &&
                   (open_bus || (grace && prev_rd_q));
  assign wr_ok_o = !ce_ni && !we_ni &&
                   (open_bus || (grace && prev_wr_q));

  assign lane_we_o = {LANES{wr_ok_o}} & ~lane_ni;
  assign wr_fire_o = |lane_we_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_rd_q <= 1'b0;
      prev_wr_q <= 1'b0;
    end else begin
      prev_rd_q <= rd_ok_o;
      prev_wr_q <= wr_ok_o;
    end
  end

  a_r6_hold_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HOLD) |-> !wr_fire_o);
endmodule

// File: rtl/shsr_array.sv
module shsr_array #(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [LANE_W*LANES-1:0]  wdata_i,
  input  logic [LANES-1:0]         lane_we_i,
  input  logic                     rd_ok_i,
  input  logic                     store_i,
  input  logic                     recall_i,
  output logic [LANE_W*LANES-1:0]  rdata_o,
  output logic                     rvalid_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANE_W * LANES;

  logic [DATA_W-1:0] work_q [DEPTH];
  logic [DATA_W-1:0] shad_q [DEPTH];
  logic [DATA_W-1:0] bit_mask;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bit_mask[l*LANE_W +: LANE_W] = {LANE_W{lane_we_i[l]}};
  end

  // whole-array transfers in one edge; arrays are not reset
  always_ff @(posedge clk_i) begin
    if (recall_i) begin
      for (int i = 0; i < DEPTH; i++) work_q[i] <= shad_q[i];
    end else if (|lane_we_i) begin
      work_q[addr_i] <= (work_q[addr_i] & ~bit_mask) | (wdata_i & bit_mask);
    end
    if (store_i) begin
      for (int i = 0; i < DEPTH; i++) shad_q[i] <= work_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_ok_i;
      if (rd_ok_i) rdata_o <= work_q[addr_i];
    end
  end
endmodule

// File: rtl/shsr_seq.sv
module shsr_seq
  import shsr_pkg::*;
#(
  parameter int DELAY_CYC  = 3,
  parameter int STORE_CYC  = 8,
  parameter int RECALL_CYC = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pin_i,
  input  logic        sw_store_i,
  input  logic        recall_i,
  input  logic        pwr_fail_i,
  input  logic        wr_fire_i,
  output shsr_state_e state_o,
  output logic        latch_o,
  output logic        store_go_o,
  output logic        recall_go_o,
  output logic        busy_o,
  output logic        pull_o,
  output logic        skip_o
);
  localparam int CNT_MAX = (DELAY_CYC > STORE_CYC) ?
                           ((DELAY_CYC > RECALL_CYC) ? DELAY_CYC : RECALL_CYC) :
                           ((STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC);
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  shsr_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             latch_q, pf_q, skip_q;
  logic             pf_rise, cnt_zero;

  assign pf_rise     = pwr_fail_i && !pf_q;
  assign cnt_zero    = (cnt_q == '0);
  assign store_go_o  = (state_q == ST_STORE)  && cnt_zero;
  assign recall_go_o = (state_q == ST_RECALL) && cnt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RECALL;
      cnt_q   <= CNT_W'(RECALL_CYC - 1);
      latch_q <= 1'b0;
      pf_q    <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      pf_q   <= pwr_fail_i;
      skip_q <= 1'b0;
      if (wr_fire_i) latch_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          // priority: line request, power fail, software store, recall
          if (!pin_i) begin
            if (latch_q) begin
              state_q <= ST_DELAY;
              cnt_q   <= CNT_W'(DELAY_CYC - 1);
            end else begin
              state_q <= ST_HOLD;
              skip_q  <= 1'b1;
            end
          end else if (pf_rise) begin
            if (latch_q) begin
              state_q <= ST_STORE;
              cnt_q   <= CNT_W'(STORE_CYC - 1);
            end else begin
              skip_q <= 1'b1;
            end
          end else if (sw_store_i) begin
            state_q <= ST_STORE;
            cnt_q   <= CNT_W'(STORE_CYC - 1);
          end else if (recall_i) begin
            state_q <= ST_RECALL;
            cnt_q   <= CNT_W'(RECALL_CYC - 1);
          end
        end
        ST_DELAY: begin
          if (cnt_zero) begin
            state_q <= ST_STORE;
            cnt_q   <= CNT_W'(STORE_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_STORE: begin
          if (cnt_zero) begin
            state_q <= ST_HOLD;
            latch_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RECALL: begin
          if (cnt_zero) begin
            state_q <= ST_IDLE;
            latch_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_HOLD: begin
          if (pin_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign latch_o = latch_q;
  assign busy_o  = (state_q == ST_STORE) || (state_q == ST_RECALL);
  assign pull_o  = (state_q == ST_STORE);
  assign skip_o  = skip_q;

  a_r4_delay_then_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DELAY && cnt_zero) |=> (state_q == ST_STORE));
  a_r10_recall_clears_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_go_o |=> !latch_q);
  a_r12_store_clears_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_go_o |=> !latch_q);
endmodule

// File: rtl/shadow_sram_ctrl.sv
module shadow_sram_ctrl
  import shsr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int LANE_W     = 8,
  parameter int DELAY_CYC  = 3,
  parameter int STORE_CYC  = 8,
  parameter int RECALL_CYC = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ce_ni,
  input  logic                oe_ni,
  input  logic                we_ni,
  input  logic                lane_lo_ni,
  input  logic                lane_hi_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*LANE_W-1:0] wdata_i,
  output logic [2*LANE_W-1:0] rdata_o,
  output logic                rvalid_o,
  input  logic                hs_ni,
  output logic                hs_pull_o,
  input  logic                sw_store_i,
  input  logic                recall_i,
  input  logic                pwr_fail_i,
  output logic                busy_o,
  output logic                skipped_o
);
  localparam int LANES = 2;

  shsr_state_e      state;
  logic             latch, store_go, recall_go;
  logic             rd_ok, wr_ok, wr_fire;
  logic [LANES-1:0] lane_we;

  shsr_seq #(
    .DELAY_CYC (DELAY_CYC),
    .STORE_CYC (STORE_CYC),
    .RECALL_CYC(RECALL_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (hs_ni),
    .sw_store_i (sw_store_i),
    .recall_i   (recall_i),
    .pwr_fail_i (pwr_fail_i),
    .wr_fire_i  (wr_fire),
    .state_o    (state),
    .latch_o    (latch),
    .store_go_o (store_go),
    .recall_go_o(recall_go),
    .busy_o     (busy_o),
    .pull_o     (hs_pull_o),
    .skip_o     (skipped_o)
  );

  shsr_gate #(.LANES(LANES)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .lane_ni  ({lane_hi_ni, lane_lo_ni}),
    .pin_i    (hs_ni),
    .state_i  (state),
    .latch_i  (latch),
    .rd_ok_o  (rd_ok),
    .wr_ok_o  (wr_ok),
    .lane_we_o(lane_we),
    .wr_fire_o(wr_fire)
  );

  shsr_array #(
    .ADDR_W(ADDR_W),
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .lane_we_i(lane_we),
    .rd_ok_i  (rd_ok),
    .store_i  (store_go),
    .recall_i (recall_go),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  a_r3_no_access_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!rd_ok && !wr_ok));
  a_r1_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok |=> rvalid_o);
  a_r12_write_sets_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> latch);
  a_r6_skip_no_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skipped_o |-> (!hs_pull_o && !busy_o));
  a_r7_pull_means_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_pull_o |-> busy_o);
endmodule

// File: tb/shadow_sram_ctrl_bench.sv
module shadow_sram_ctrl_bench;
  localparam int AW  = 4;
  localparam int DLY = 3;
  localparam int STC = 8;
  localparam int RCC = 6;
  localparam int NW  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n, oe_n, we_n, lo_n, hi_n;
  logic [AW-1:0] addr;
  logic [15:0]   wdata, rdata;
  logic          rvalid, hs_pull, hs_pin, busy, skipped;
  logic          sw_store = 1'b0, recall = 1'b0, pf = 1'b0, ext_low = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_work [NW];
  logic [15:0] m_shad [NW];
  logic [15:0] exp_q [$];

  always #2 clk = ~clk;  // 250 MHz
  assign hs_pin = !(ext_low || hs_pull);

  shadow_sram_ctrl #(
    .ADDR_W(AW), .LANE_W(8), .DELAY_CYC(DLY), .STORE_CYC(STC), .RECALL_CYC(RCC)
  ) u_shadow_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .lane_lo_ni(lo_n), .lane_hi_ni(hi_n), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .hs_ni(hs_pin), .hs_pull_o(hs_pull),
    .sw_store_i(sw_store), .recall_i(recall), .pwr_fail_i(pf),
    .busy_o(busy), .skipped_o(skipped)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; lo_n = 1'b1; hi_n = 1'b1;
  endtask

  task automatic snap_store();
    for (int i = 0; i < NW; i++) m_shad[i] = m_work[i];
  endtask

  task automatic snap_recall();
    for (int i = 0; i < NW; i++) m_work[i] = m_shad[i];
  endtask

  // called at a falling edge, occupies one cycle
  task automatic wr(input int a, input logic [15:0] d, input logic [1:0] en, input bit ok);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    lo_n = !en[0]; hi_n = !en[1]; addr = AW'(a); wdata = d;
    @(negedge clk);
    idle_bus();
    if (ok) begin
      if (en[0]) m_work[a][7:0]  = d[7:0];
      if (en[1]) m_work[a][15:8] = d[15:8];
    end
  endtask

  task automatic rd(input int a, input bit ok, input string tag);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(a);
    if (ok) exp_q.push_back(m_work[a]);
    @(posedge clk); #1;
    if (!ok) chk(tag, 32'(rvalid), 32'd0);
    @(negedge clk);
    idle_bus();
  endtask

  task automatic count_until(input logic want, output int n);
    n = 0;
    while (busy !== want && n < 500) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R3 unexpected read data: actual %0h expected none", rdata);
      end else begin
        chk("R1 R2 readback", 32'(rdata), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    idle_bus(); addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R11 busy during reset", 32'(busy), 32'd1);
    chk("R7 no pull during reset", 32'(hs_pull), 32'd0);
    rst_n = 1'b1;
    count_until(1'b0, n);
    chk("R11 power-up recall length", n, RCC);
    @(negedge clk);
    snap_recall();

    // R2 lanes, R1 reads
    wr(1, 16'hA1B2, 2'b11, 1); rd(1, 1, "R1");
    wr(1, 16'h5C5C, 2'b01, 1); rd(1, 1, "R2");
    wr(1, 16'h3E77, 2'b10, 1); rd(1, 1, "R2");
    wr(2, 16'h1234, 2'b11, 1);
    wr(2, 16'hFFFF, 2'b00, 1); rd(2, 1, "R2");
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 1;
    @(posedge clk); #1; chk("R1 no read with oe high", 32'(rvalid), 32'd0);
    @(negedge clk); idle_bus();
    ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    @(posedge clk); #1; chk("R1 no read with ce high", 32'(rvalid), 32'd0);
    @(negedge clk); idle_bus();

    // R9 software store, dirty
    sw_store = 1'b1;
    @(posedge clk); #1; sw_store = 1'b0;
    chk("R9 store started", 32'(busy), 32'd1);
    chk("R7 pull during sw store", 32'(hs_pull), 32'd1);
    chk("R7 line low during store", 32'(hs_pin), 32'd0);
    count_until(1'b0, n);
    chk("R9 store length", n, STC);
    chk("R7 pull released", 32'(hs_pull), 32'd0);
    @(negedge clk); snap_store(); repeat (2) @(negedge clk);

    // R9 software store, clean
    sw_store = 1'b1;
    @(posedge clk); #1; sw_store = 1'b0;
    chk("R9 clean store still runs", 32'(busy), 32'd1);
    count_until(1'b0, n);
    @(negedge clk); snap_store(); repeat (2) @(negedge clk);

    // R8 skip when clean
    pf = 1'b1;
    @(posedge clk); #1;
    chk("R8 clean power fail skipped", 32'(skipped), 32'd1);
    chk("R8 clean power fail no busy", 32'(busy), 32'd0);
    @(negedge clk); pf = 1'b0; @(negedge clk);

    // R12 write with no lane leaves latch clear
    wr(3, 16'hDEAD, 2'b00, 1);
    pf = 1'b1;
    @(posedge clk); #1;
    chk("R12 laneless write keeps latch clear", 32'(skipped), 32'd1);
    @(negedge clk); pf = 1'b0; @(negedge clk);

    // R8 store on power fail, R3 inhibit
    wr(3, 16'hBEEF, 2'b11, 1);
    pf = 1'b1;
    @(posedge clk); #1;
    chk("R8 dirty power fail stores", 32'(busy), 32'd1);
    chk("R7 pull during auto store", 32'(hs_pull), 32'd1);
    @(negedge clk);
    rd(1, 0, "R3 read during store");
    wr(2, 16'h9999, 2'b11, 0);
    count_until(1'b0, n);
    @(negedge clk); pf = 1'b0; snap_store(); repeat (2) @(negedge clk);
    rd(2, 1, "R3"); rd(3, 1, "R8");

    // R6 clean line request
    ext_low = 1'b1;
    @(posedge clk); #1;
    chk("R6 skipped flag", 32'(skipped), 32'd1);
    chk("R6 no pull", 32'(hs_pull), 32'd0);
    chk("R6 no busy", 32'(busy), 32'd0);
    @(negedge clk);
    rd(2, 0, "R6 read while line held");
    wr(2, 16'h0F0F, 2'b11, 0);
    ext_low = 1'b0;
    repeat (2) @(negedge clk);
    rd(2, 1, "R6");

    // R4 dirty line request timing
    wr(4, 16'h4444, 2'b11, 1);
    ext_low = 1'b1;
    count_until(1'b1, n);
    chk("R4 delay before store", n, DLY + 1);
    chk("R7 pull during line store", 32'(hs_pull), 32'd1);
    count_until(1'b0, n);
    chk("R4 store length", n, STC);
    @(negedge clk); ext_low = 1'b0; snap_store(); repeat (2) @(negedge clk);

    // R5 fresh write after fall refused
    wr(5, 16'h5555, 2'b11, 1);
    @(negedge clk);
    ext_low = 1'b1;
    wr(5, 16'hAAAA, 2'b11, 0);
    count_until(1'b1, n);
    count_until(1'b0, n);
    @(negedge clk); ext_low = 1'b0; snap_store(); repeat (2) @(negedge clk);
    rd(5, 1, "R5");

    // R5 continuing write finishes in grace
    ce_n = 1'b0; we_n = 1'b0; lo_n = 1'b0; hi_n = 1'b0; addr = 6; wdata = 16'h6666;
    @(negedge clk);
    wdata = 16'h6767; ext_low = 1'b1;
    @(negedge clk);
    idle_bus(); m_work[6] = 16'h6767;
    count_until(1'b1, n);
    count_until(1'b0, n);
    @(negedge clk); ext_low = 1'b0; snap_store(); repeat (2) @(negedge clk);
    rd(6, 1, "R5");

    // R10 recall
    wr(1, 16'h0101, 2'b11, 1);
    recall = 1'b1;
    @(posedge clk); #1; recall = 1'b0;
    chk("R10 recall busy", 32'(busy), 32'd1);
    chk("R10 no pull in recall", 32'(hs_pull), 32'd0);
    count_until(1'b0, n);
    chk("R10 recall length", n, RCC);
    @(negedge clk); snap_recall();
    rd(1, 1, "R10");
    pf = 1'b1;
    @(posedge clk); #1;
    chk("R10 recall cleared latch", 32'(skipped), 32'd1);
    @(negedge clk); pf = 1'b0; @(negedge clk);

    // R11 persistence over reset
    wr(7, 16'h7777, 2'b11, 1);
    sw_store = 1'b1;
    @(posedge clk); #1; sw_store = 1'b0;
    count_until(1'b0, n);
    @(negedge clk); snap_store(); repeat (2) @(negedge clk);
    wr(7, 16'h0000, 2'b11, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    count_until(1'b0, n);
    chk("R11 recall after reset", n, RCC);
    @(negedge clk); snap_recall();
    rd(7, 1, "R11"); rd(6, 1, "R11");

    repeat (3) @(negedge clk);
    chk("R1 all reads returned", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule